// File: doc/BRIEF.md
# Switch/LED Multiplex Controller

This block shares one group of column pins among three jobs: keyboard contact sensing, reading a switch matrix, and driving an LED matrix. Each row of the matrix gets a fixed time slot. A phase output divides that slot into two windows. While the phase is high, the keyboard logic has the pins and the LED drivers stay off. While the phase is low, the block first waits a guard interval. It then drives the LED word of the current row onto the LED columns. Near the end of the window it latches the switch columns of that row.

A host uses a small word-addressed port to write LED words and read them back. It reads switch words through the same port. When the block stores a switch word whose value differs from the stored one, it sets a change flag for that row. The flag is returned together with the word, and reading the word clears it.

All timing is counted in scan ticks, and one scan tick is a fixed number of system clocks. With the default parameters the keyboard window is 4 ticks and the switch/LED window is 12 ticks, so one row slot is 16 ticks.

Top module: `shsl_mux_ctrl`

## Requirements
- R1: During reset and after its release: `kbd_phase_o` is 1, `led_oe_o` is 0, `row_o` is 0 and `led_col_o` is 0. Every LED word, switch word and change flag reads back as 0.
- R2: `kbd_phase_o` stays high for KBD_TICKS scan ticks and low for IO_TICKS scan ticks. One scan tick is SCLK_DIV clocks, so with the defaults the phase is high for 64 clocks and low for 192 clocks.
- R3: `row_o` advances by one in the same cycle that `kbd_phase_o` rises. After NROWS-1 it wraps to 0, and it does not change at any other time.
- R4: `led_oe_o` is 0 whenever `kbd_phase_o` is 1. It rises exactly GUARD_CLKS clocks after the phase falls (4 by default), and it drops in the same cycle that the phase rises.
- R5: LED words 0 to LED_ROWS-1 live at host addresses 0x58 + row. While `led_oe_o` is 1, `led_col_o` equals the LED word of `row_o`. For rows at or above LED_ROWS (8), `led_oe_o` stays 0. Whenever `led_oe_o` is 0, `led_col_o` is 0.
- R6: The switch word of row r is stored at address 0x60 + r, with bit i taken from `sw_col_i[i]`. The block takes the value present at the clock edge that ends the second-to-last scan tick of the low window. With the defaults, that edge is 176 clocks after the phase falls.
- R7: A stored switch value that differs from the previous one sets that row's change flag. A read of the switch word returns the flag on `host_chg_o` and clears it. If a new change and the clearing read happen in the same cycle, the change wins.
- R8: A read with `host_re_i` returns its data on `host_rdata_o` one clock later. Switch words cannot be written by the host. Any address outside the LED and switch ranges reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_phase_o | output | 1 | 1 = keyboard window, 0 = switch/LED window |
| row_o | output | ROW_W (4) | Row select of the current slot |
| sw_col_i | input | NCOL (11) | Switch column inputs |
| led_col_o | output | NCOL (11) | LED column data |
| led_oe_o | output | 1 | Output enable for the LED column pads |
| host_addr_i | input | 7 | Host word address |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | NCOL (11) | Host write data |
| host_re_i | input | 1 | Host read strobe |
| host_rdata_o | output | NCOL (11) | Read data, valid one clock after the read strobe |
| host_chg_o | output | 1 | Change flag of the switch word that was read |

## Verification
The assertions assume that `sw_col_i` is stable around the sampling edge. They also assume that the host issues at most one read or one write per cycle, using addresses of the stated width. The bench changes switch inputs and host signals only on falling clock edges. It places its late switch changes a few clocks before or after the sampling edge, never on it. It issues one host request at a time, so every captured word and returned flag has a single expected value.

// File: rtl/shsl_pkg.sv
package shsl_pkg;
  localparam int ADDR_W      = 7;
  localparam int LED_BASE    = 'h58;
  localparam int SW_BASE     = 'h60;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_LED  = 2'd1,
    HIT_SW   = 2'd2
  } hit_e;
endpackage

// File: rtl/shsl_slot_timer.sv
module shsl_slot_timer #(
  parameter int SCLK_DIV   = 16,
  parameter int KBD_TICKS  = 4,
  parameter int IO_TICKS   = 12,
  parameter int NROWS      = 16,
  parameter int ROW_W      = 4,
  parameter int GUARD_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             kbd_o,
  output logic [ROW_W-1:0] row_o,
  output logic             io_open_o,
  output logic             sample_o
);
  localparam int SLOT   = KBD_TICKS + IO_TICKS;
  localparam int SLOT_W = $clog2(SLOT + 1);
  localparam int DIV_W  = $clog2(SCLK_DIV + 1);
  localparam int GRD_W  = $clog2(GUARD_CLKS + 1);
  localparam logic [DIV_W-1:0]  DIV_MAX  = DIV_W'(SCLK_DIV - 1);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(SLOT - 1);
  localparam logic [SLOT_W-1:0] SMP_POS  = SLOT_W'(SLOT - 2);
  localparam logic [SLOT_W-1:0] KBD_END  = SLOT_W'(KBD_TICKS);
  localparam logic [ROW_W-1:0]  ROW_MAX  = ROW_W'(NROWS - 1);
  localparam logic [GRD_W-1:0]  GRD_MAX  = GRD_W'(GUARD_CLKS);

  logic [DIV_W-1:0]  div_q,  div_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [ROW_W-1:0]  row_q,  row_d;
  logic [GRD_W-1:0]  grd_q,  grd_d;
  logic              tick, slot_end, kbd, slot_en, row_en;

  always_comb begin
    tick     = (div_q == DIV_MAX);
    kbd      = (slot_q < KBD_END);
    slot_end = tick && (slot_q == SLOT_MAX);
    div_d    = tick ? '0 : div_q + 1'b1;
    slot_en  = tick;
    slot_d   = (slot_q == SLOT_MAX) ? '0 : slot_q + 1'b1;
    row_en   = slot_end;
    row_d    = (row_q == ROW_MAX) ? '0 : row_q + 1'b1;
    if (kbd)                  grd_d = '0;
    else if (grd_q == GRD_MAX) grd_d = grd_q;
    else                      grd_d = grd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
      row_q  <= '0;
      grd_q  <= '0;
    end else begin
      div_q <= div_d;
      grd_q <= grd_d;
      if (slot_en) slot_q <= slot_d;
      if (row_en)  row_q  <= row_d;
    end
  end

  assign kbd_o     = kbd;
  assign row_o     = row_q;
  assign io_open_o = !kbd && (grd_q == GRD_MAX);
  assign sample_o  = tick && (slot_q == SMP_POS);
endmodule

// File: rtl/shsl_led_bank.sv
module shsl_led_bank #(
  parameter int NCOL      = 11,
  parameter int LED_ROWS  = 8,
  parameter int LED_ROW_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [LED_ROW_W-1:0] wr_idx_i,
  input  logic [NCOL-1:0]      wr_data_i,
  input  logic [LED_ROW_W-1:0] rd_idx_i,
  output logic [NCOL-1:0]      rd_data_o,
  input  logic [LED_ROW_W-1:0] drv_idx_i,
  output logic [NCOL-1:0]      drv_data_o
);
  logic [NCOL-1:0] led_q [LED_ROWS];

  for (genvar g = 0; g < LED_ROWS; g++) begin : g_led
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == LED_ROW_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   led_q[g] <= '0;
      else if (hit) led_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o  = led_q[rd_idx_i];
  assign drv_data_o = led_q[drv_idx_i];
endmodule

// File: rtl/shsl_sw_bank.sv
module shsl_sw_bank #(
  parameter int NCOL  = 11,
  parameter int NROWS = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en_i,
  input  logic [ROW_W-1:0] smp_row_i,
  input  logic [NCOL-1:0]  smp_data_i,
  input  logic             rd_en_i,
  input  logic [ROW_W-1:0] rd_idx_i,
  output logic [NCOL-1:0]  rd_data_o,
  output logic             rd_chg_o
);
  logic [NCOL-1:0] sw_q [NROWS];
  logic [NROWS-1:0] chg_q, chg_d;
  logic [NROWS-1:0] set_v, clr_v;

  for (genvar g = 0; g < NROWS; g++) begin : g_sw
    logic smp_hit;
    assign smp_hit  = smp_en_i && (smp_row_i == ROW_W'(g));
    assign set_v[g] = smp_hit && (smp_data_i != sw_q[g]);
    assign clr_v[g] = rd_en_i && (rd_idx_i == ROW_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sw_q[g] <= '0;
      else if (smp_hit) sw_q[g] <= smp_data_i;
    end
  end

  always_comb chg_d = (chg_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= chg_d;
  end

  assign rd_data_o = sw_q[rd_idx_i];
  assign rd_chg_o  = chg_q[rd_idx_i];
endmodule

// File: rtl/shsl_mux_ctrl.sv
module shsl_mux_ctrl
  import shsl_pkg::*;
#(
  parameter int NCOL       = 11,
  parameter int NROWS      = 16,
  parameter int ROW_W      = 4,
  parameter int LED_ROWS   = 8,
  parameter int SCLK_DIV   = 16,
  parameter int KBD_TICKS  = 4,
  parameter int IO_TICKS   = 12,
  parameter int GUARD_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              kbd_phase_o,
  output logic [ROW_W-1:0]  row_o,
  input  logic [NCOL-1:0]   sw_col_i,
  output logic [NCOL-1:0]   led_col_o,
  output logic              led_oe_o,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_we_i,
  input  logic [NCOL-1:0]   host_wdata_i,
  input  logic              host_re_i,
  output logic [NCOL-1:0]   host_rdata_o,
  output logic              host_chg_o
);
  localparam int LED_ROW_W = (LED_ROWS > 1) ? $clog2(LED_ROWS) : 1;

  logic             kbd, io_open, sample;
  logic [ROW_W-1:0] row;
  logic [NCOL-1:0]  led_rd, led_drv, sw_rd;
  logic             sw_chg;
  hit_e             hit;
  int unsigned      addr_u;
  logic [ADDR_W-1:0] off_led, off_sw;
  logic [NCOL-1:0]  rdata_q, rdata_d;
  logic             chg_q, chg_d;
  logic             row_has_led;

  shsl_slot_timer #(
    .SCLK_DIV(SCLK_DIV), .KBD_TICKS(KBD_TICKS), .IO_TICKS(IO_TICKS),
    .NROWS(NROWS), .ROW_W(ROW_W), .GUARD_CLKS(GUARD_CLKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .kbd_o(kbd), .row_o(row),
    .io_open_o(io_open), .sample_o(sample)
  );

  always_comb begin
    addr_u  = int'(host_addr_i);
    off_led = host_addr_i - ADDR_W'(LED_BASE);
    off_sw  = host_addr_i - ADDR_W'(SW_BASE);
    if (addr_u >= LED_BASE && addr_u < LED_BASE + LED_ROWS)  hit = HIT_LED;
    else if (addr_u >= SW_BASE && addr_u < SW_BASE + NROWS)  hit = HIT_SW;
    else                                                     hit = HIT_NONE;
  end

  shsl_led_bank #(
    .NCOL(NCOL), .LED_ROWS(LED_ROWS), .LED_ROW_W(LED_ROW_W)
  ) u_led (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(host_we_i && hit == HIT_LED),
    .wr_idx_i(off_led[LED_ROW_W-1:0]),
    .wr_data_i(host_wdata_i),
    .rd_idx_i(off_led[LED_ROW_W-1:0]),
    .rd_data_o(led_rd),
    .drv_idx_i(row[LED_ROW_W-1:0]),
    .drv_data_o(led_drv)
  );

  shsl_sw_bank #(
    .NCOL(NCOL), .NROWS(NROWS), .ROW_W(ROW_W)
  ) u_sw (
    .clk(clk), .rst_n(rst_n),
    .smp_en_i(sample), .smp_row_i(row), .smp_data_i(sw_col_i),
    .rd_en_i(host_re_i && hit == HIT_SW),
    .rd_idx_i(off_sw[ROW_W-1:0]),
    .rd_data_o(sw_rd), .rd_chg_o(sw_chg)
  );

  always_comb begin
    row_has_led = (int'(row) < LED_ROWS);
    case (hit)
      HIT_LED: begin rdata_d = led_rd; chg_d = 1'b0;   end
      HIT_SW:  begin rdata_d = sw_rd;  chg_d = sw_chg; end
      default: begin rdata_d = '0;     chg_d = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      chg_q   <= 1'b0;
    end else if (host_re_i) begin
      rdata_q <= rdata_d;
      chg_q   <= chg_d;
    end
  end

  assign kbd_phase_o  = kbd;
  assign row_o        = row;
  assign led_oe_o     = io_open && row_has_led;
  assign led_col_o    = led_oe_o ? led_drv : '0;
  assign host_rdata_o = rdata_q;
  assign host_chg_o   = chg_q;
endmodule

// File: rtl/shsl_mux_chk.sv
module shsl_mux_chk #(
  parameter int NCOL  = 11,
  parameter int NROWS = 16,
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kbd_phase_o,
  input logic             led_oe_o,
  input logic [ROW_W-1:0] row_o,
  input logic [NCOL-1:0]  led_col_o
);
  assert_oe_off_in_kbd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    led_oe_o |-> !kbd_phase_o);

  assert_guard_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kbd_phase_o) |-> !led_oe_o);

  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(kbd_phase_o) |-> $stable(row_o));

  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_phase_o) |->
      (($past(row_o) == ROW_W'(NROWS - 1)) ? (row_o == '0)
                                            : (row_o == $past(row_o) + 1'b1)));

  assert_cols_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !led_oe_o |-> (led_col_o == '0));
endmodule

bind shsl_mux_ctrl shsl_mux_chk #(.NCOL(NCOL), .NROWS(NROWS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kbd_phase_o(kbd_phase_o), .led_oe_o(led_oe_o),
  .row_o(row_o), .led_col_o(led_col_o)
);

// File: tb/tb_shsl_mux_ctrl.sv
module tb_shsl_mux_ctrl;
  localparam int NCOL = 11;
  localparam int NROWS = 16;
  localparam int KBD_CLKS = 64;
  localparam int IO_CLKS = 192;
  localparam int GUARD = 4;
  localparam int SMP_OFS = 176;

  logic clk = 1'b0;
  logic rst_n;
  logic kbd, oe, re, we, chg;
  logic [3:0] row;
  logic [NCOL-1:0] sw_col, led_col, wdata, rdata;
  logic [6:0] addr;
  logic [NCOL-1:0] sw_model [NROWS];
  logic [NCOL-1:0] led_model [8];
  logic ovr_en;
  logic [NCOL-1:0] ovr_val;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sw_col = ovr_en ? ovr_val : sw_model[row];

  shsl_mux_ctrl dut (
    .clk(clk), .rst_n(rst_n), .kbd_phase_o(kbd), .row_o(row),
    .sw_col_i(sw_col), .led_col_o(led_col), .led_oe_o(oe),
    .host_addr_i(addr), .host_we_i(we), .host_wdata_i(wdata),
    .host_re_i(re), .host_rdata_o(rdata), .host_chg_o(chg)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(int a, int d);
    @(negedge clk);
    addr = 7'(a); wdata = NCOL'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic hread(int a, output int d, output int c);
    @(negedge clk);
    addr = 7'(a); re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = int'(rdata); c = int'(chg);
  endtask

  task automatic wait_fall_of_row(int r);
    @(negedge clk);
    while (!(int'(row) == r && kbd)) @(negedge clk);
    while (kbd) @(negedge clk);
  endtask

  task automatic t_reset();
    int d, c;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", int'(kbd), 1);
    chk("R1 oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 row", int'(row), 0);
    chk("R1 led cols", int'(led_col), 0);
    hread('h58, d, c);
    chk("R1 led word", d, 0);
    hread('h65, d, c);
    chk("R1 switch word", d, 0);
    chk("R1 change flag", c, 0);
  endtask

  task automatic t_phase_timing();
    int n;
    @(negedge clk);
    while (kbd) @(negedge clk);
    while (!kbd) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (kbd);
    chk("R2 high window clocks", n, KBD_CLKS);
    n = 0;
    do begin @(negedge clk); n++; end while (!kbd);
    chk("R2 low window clocks", n, IO_CLKS);
  endtask

  task automatic t_guard();
    int n;
    bit bad_kbd = 0, bad_drop = 0;
    wait_fall_of_row(0);
    chk("R4 oe at phase fall", int'(oe), 0);
    n = 0;
    while (!oe && n < 100) begin @(negedge clk); n++; end
    chk("R4 guard clocks", n, GUARD);
    while (!kbd) begin
      if (!oe) bad_drop = 1;
      @(negedge clk);
    end
    chk("R4 oe held to end of low window", int'(bad_drop), 0);
    repeat (KBD_CLKS) begin
      if (oe) bad_kbd = 1;
      @(negedge clk);
    end
    chk("R4 oe off in keyboard window", int'(bad_kbd), 0);
  endtask

  task automatic t_row_walk();
    int prev, bad = 0;
    @(negedge clk);
    while (kbd) @(negedge clk);
    prev = int'(row);
    for (int i = 0; i < NROWS + 1; i++) begin
      while (!kbd) @(negedge clk);
      if (int'(row) != (prev + 1) % NROWS) bad++;
      prev = int'(row);
      while (kbd) begin
        if (int'(row) != prev) bad++;
        @(negedge clk);
      end
    end
    chk("R3 row step and wrap", bad, 0);
  endtask

  task automatic t_led_drive();
    int seen [NROWS];
    int bad_val = 0, bad_hi = 0, d, c;
    for (int r = 0; r < 8; r++) begin
      led_model[r] = NCOL'(11'h155 ^ (r * 'h93));
      hwrite('h58 + r, int'(led_model[r]));
    end
    for (int r = 0; r < NROWS; r++) seen[r] = 0;
    repeat (NROWS * 256 + 256) begin
      @(negedge clk);
      if (oe) begin
        seen[row]++;
        if (int'(row) >= 8) bad_hi++;
        else if (led_col != led_model[row[2:0]]) bad_val++;
      end else if (led_col != '0) bad_val++;
    end
    chk("R5 driven LED data", bad_val, 0);
    chk("R5 no drive above LED rows", bad_hi, 0);
    chk("R5 row 3 driven", int'(seen[3] > 0), 1);
    chk("R5 row 7 driven", int'(seen[7] > 0), 1);
    hread('h5B, d, c);
    chk("R8 LED readback", d, int'(led_model[3]));
  endtask

  task automatic t_switch_frame();
    int d, c;
    for (int r = 0; r < NROWS; r++) sw_model[r] = NCOL'((r * 'h2D) ^ 'h4A1);
    sw_model[9] = '0;
    repeat (NROWS * 256 + 300) @(negedge clk);
    for (int r = 0; r < NROWS; r++) begin
      hread('h60 + r, d, c);
      chk($sformatf("R6 switch word row %0d", r), d, int'(sw_model[r]));
      chk($sformatf("R7 change flag row %0d", r), c, (r == 9) ? 0 : 1);
    end
    hread('h64, d, c);
    chk("R7 flag cleared by read", c, 0);
    repeat (NROWS * 256 + 300) @(negedge clk);
    hread('h64, d, c);
    chk("R7 no flag for equal sample", c, 0);
  endtask

  task automatic t_sample_point();
    int d, c;
    wait_fall_of_row(5);
    ovr_val = 11'h0F0; ovr_en = 1'b1;
    repeat (SMP_OFS - 4) @(negedge clk);
    ovr_val = 11'h30C;
    while (!kbd) @(negedge clk);
    ovr_en = 1'b0;
    hread('h65, d, c);
    chk("R6 change before sample edge taken", d, 'h30C);
    wait_fall_of_row(6);
    ovr_val = 11'h0F0; ovr_en = 1'b1;
    repeat (SMP_OFS + 4) @(negedge clk);
    ovr_val = 11'h30C;
    while (!kbd) @(negedge clk);
    ovr_en = 1'b0;
    hread('h66, d, c);
    chk("R6 change after sample edge ignored", d, 'h0F0);
  endtask

  task automatic t_host_decode();
    int d, c;
    hwrite('h10, 'h7FF);
    hread('h10, d, c);
    chk("R8 unmapped read zero", d, 0);
    hwrite('h61, 'h3AA);
    hread('h61, d, c);
    chk("R8 switch word not writable", d, int'(sw_model[1]));
    hread('h58, d, c);
    chk("R8 LED word untouched by stray writes", d, int'(led_model[0]));
    hwrite('h5F, 'h1);
    hread('h5F, d, c);
    chk("R8 last LED address", d, 1);
    addr = 7'h5F; re = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 read data held without strobe", int'(rdata), 1);
  endtask

  initial begin
    we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    ovr_en = 1'b0; ovr_val = '0;
    for (int r = 0; r < NROWS; r++) sw_model[r] = '0;
    for (int r = 0; r < 8; r++) led_model[r] = '0;
    t_reset();
    t_phase_timing();
    t_guard();
    t_row_walk();
    t_led_drive();
    t_switch_frame();
    t_sample_point();
    t_host_decode();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected run end", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule